// File: doc/BRIEF.md
# Beat-wise Vector Carry-Chain Adder

This unit adds or subtracts two 128-bit vector operands as four 32-bit lanes, working on one lane per clock beat. The carry leaving one lane enters the next, so the whole vector behaves like one wide add or subtract that is carried out in pieces. A single carry flag register holds the carry between operations. It can supply the carry into the first lane, and it always receives the carry out of the last lane.

A start pulse captures the operands, a 2-bit opcode, a per-beat enable mask and a first-beat-skipped indicator. The beats then run on their own, one per cycle. A disabled beat leaves its result lane untouched and passes the carry through unchanged. If the first beat is marked as skipped, lane 0 is neither computed nor written. The operation then takes its initial carry from the flag, even when the opcode asks for a fixed constant. This is how an interrupted operation resumes. A one-cycle done pulse marks the cycle in which the flag first shows the new carry.

Top module: `vcarry_chain`

## Requirements
- R1: In add mode, an enabled lane i (bits 32*i+31 down to 32*i) is written with the low 32 bits of a_i lane + b_i lane + carry-in, and its carry-out is bit 32 of that sum. Lane i is handled on beat i.
- R2: In subtract mode (op_i bit 0 = 1), an enabled lane is written with a - b - (1 - carry-in) modulo 2^32. Its carry-out is 1 exactly when no borrow occurs, that is when a >= b + (1 - carry-in).
- R3: The carry-out of the beat for lane i is the carry-in of the beat for lane i+1.
- R4: Opcode 2'b10 (fixed add) uses carry-in 0 for the first executed lane when the first beat is not skipped.
- R5: Opcode 2'b11 (fixed subtract) uses carry-in 1 for the first executed lane when the first beat is not skipped.
- R6: Opcodes 2'b00 (flag add) and 2'b01 (flag subtract) take the first carry-in from carry_flag_o.
- R7: The carry out of the last beat is written to carry_flag_o. The flag does not change at any other time.
- R8: With skip_first_i = 1, execution begins at beat 1. Lane 0 of result_o keeps its old value, and the initial carry is carry_flag_o whatever the opcode.
- R9: A beat whose bit in beat_en_i (bit i for lane i, captured at start) is 0 leaves that result lane unchanged and passes its carry-in on unchanged.
- R10: done_o is high for exactly one cycle. It rises 4 cycles after the start edge (3 when the first beat is skipped), in the same cycle that carry_flag_o first shows the new carry.
- R11: start_i is ignored while busy_o is 1. The running operation finishes with its original operands.
- R12: After reset, result_o = 0, carry_flag_o = 0, done_o = 0 and busy_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation; accepted only when idle |
| skip_first_i | input | 1 | First beat was already done or is skipped; resume at beat 1 |
| op_i | input | 2 | bit 0: subtract; bit 1: fixed initial carry |
| beat_en_i | input | 4 | Per-beat enable mask, bit i for lane i |
| a_i | input | 128 | First vector operand |
| b_i | input | 128 | Second vector operand |
| result_o | output | 128 | Result vector, one 32-bit lane per beat |
| carry_flag_o | output | 1 | Stored carry flag |
| busy_o | output | 1 | Beats in progress |
| done_o | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions assume that start_i is a clean synchronous level and that op_i, skip_first_i, beat_en_i and the operands are valid in the cycle start_i is sampled. They do not assume that the inputs hold afterwards, because the unit captures everything at start. The stimulus changes inputs only on the falling edge. It raises start only when idle, except in the deliberate start-while-busy case, and there it also changes the operands so that any wrongful capture would show. Operand patterns are chosen to drive a carry across every lane, to cause borrows, and to combine masks and skipped first beats with each opcode.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int unsigned LANE_W = 32;

  typedef enum logic [1:0] {
    OP_ADD_FLAG = 2'b00,
    OP_SUB_FLAG = 2'b01,
    OP_ADD_FIX  = 2'b10,
    OP_SUB_FIX  = 2'b11
  } vcc_op_e;

  // one lane: a + (sub ? ~b : b) + cin, returns {cout, sum}
  function automatic logic [LANE_W:0] lane_step(input logic [LANE_W-1:0] a,
                                                 input logic [LANE_W-1:0] b,
                                                 input logic sub,
                                                 input logic cin);
    logic [LANE_W-1:0] bx;
    bx = sub ? ~b : b;
    return {1'b0, a} + {1'b0, bx} + {{LANE_W{1'b0}}, cin};
  endfunction

  // carry into the first executed lane
  function automatic logic first_carry(input logic [1:0] op,
                                       input logic skip,
                                       input logic flag);
    if (op[1] && !skip) return op[0];
    return flag;
  endfunction
endpackage

// File: rtl/vcc_lane_alu.sv
module vcc_lane_alu
  import vcc_pkg::*;
#(
  parameter int unsigned W = LANE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] bx;
  logic [W:0]   full;

  always_comb begin
    bx   = sub ? ~b : b;
    full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/vcc_beat_seq.sv
module vcc_beat_seq #(
  parameter int unsigned LANES = 4,
  localparam int unsigned BW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          skip_first,
  output logic          accept,
  output logic          busy,
  output logic [BW-1:0] beat,
  output logic          last
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(LANES - 1);

  assign accept = start && !busy;
  assign last   = (beat == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      beat <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      beat <= skip_first ? BW'(1) : '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      beat <= beat + 1'b1;
    end
  end

  // R3: lanes are taken in ascending order, one per cycle
  p_beat_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && beat == $past(beat) + 1'b1);

  // R8: a skipped first beat starts the run at lane 1
  p_skip_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && skip_first |=> busy && beat == BW'(1));

  // R10: the run ends right after the last beat
  p_end_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && last |=> !busy);
endmodule

// File: rtl/vcarry_chain.sv
module vcarry_chain
  import vcc_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned LANES = VEC_W / LANE_W,
  localparam int unsigned BW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             skip_first_i,
  input  logic [1:0]       op_i,
  input  logic [LANES-1:0] beat_en_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] result_o,
  output logic             carry_flag_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [VEC_W-1:0]  a_q, b_q, result_q;
  logic [1:0]        op_q;
  logic [LANES-1:0]  en_q;
  logic              carry_q, flag_q, done_q;

  // named internal events
  logic              accept, busy, last, exec_last, lane_en;
  logic [BW-1:0]     beat;
  logic [LANE_W-1:0] lane_a, lane_b, lane_sum;
  logic              lane_cout, carry_next;

  vcc_beat_seq #(.LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .skip_first (skip_first_i),
    .accept     (accept),
    .busy       (busy),
    .beat       (beat),
    .last       (last)
  );

  assign lane_a     = a_q[beat*LANE_W +: LANE_W];
  assign lane_b     = b_q[beat*LANE_W +: LANE_W];
  assign lane_en    = en_q[beat];
  assign exec_last  = busy && last;

  vcc_lane_alu #(.W(LANE_W)) u_alu (
    .a    (lane_a),
    .b    (lane_b),
    .sub  (op_q[0]),
    .cin  (carry_q),
    .sum  (lane_sum),
    .cout (lane_cout)
  );

  assign carry_next = lane_en ? lane_cout : carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= 2'b00;
      en_q    <= '0;
      carry_q <= 1'b0;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= exec_last;
      if (accept) begin
        a_q     <= a_i;
        b_q     <= b_i;
        op_q    <= op_i;
        en_q    <= beat_en_i;
        carry_q <= first_carry(op_i, skip_first_i, flag_q);
      end else if (busy) begin
        carry_q <= carry_next;
        if (last) flag_q <= carry_next;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        result_q[g*LANE_W +: LANE_W] <= '0;
      else if (busy && lane_en && beat == BW'(g))
        result_q[g*LANE_W +: LANE_W] <= lane_sum;
    end
  end

  assign result_o     = result_q;
  assign carry_flag_o = flag_q;
  assign busy_o       = busy;
  assign done_o       = done_q;

  // R4: fixed add starts from a clear carry
  p_fix_add_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_i == OP_ADD_FIX && !skip_first_i |=> carry_q == 1'b0);

  // R5: fixed subtract starts from a set carry
  p_fix_sub_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_i == OP_SUB_FIX && !skip_first_i |=> carry_q == 1'b1);

  // R6 and R8: flag modes and resumed runs start from the stored flag
  p_flag_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (!op_i[1] || skip_first_i) |=> carry_q == $past(flag_q));

  // R7: the flag moves only on the final beat
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_last |=> $stable(flag_q));

  // R9: a disabled beat touches neither the result nor the carry
  p_masked_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !lane_en |=> $stable(result_q) && $stable(carry_q));

  // R10: done follows the final beat and lasts one cycle
  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_last |=> done_q);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11: a start during a run does not reload the operands
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_i |=> $stable(a_q) && $stable(b_q) && $stable(op_q));
endmodule

// File: tb/vcarry_chain_bench.sv
`timescale 1ns/100ps
module vcarry_chain_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         skip_first_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [3:0]   beat_en_i = 4'hF;
  logic [127:0] a_i = '0, b_i = '0;
  logic [127:0] result_o;
  logic         carry_flag_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vcarry_chain u_vcarry_chain (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .skip_first_i(skip_first_i),
    .op_i(op_i), .beat_en_i(beat_en_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .carry_flag_o(carry_flag_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    logic [127:0] res;
    logic         flag;
    logic         flag_before;
    int           done_cyc;
    string        tag;
  } item_t;

  item_t sbq[$];
  logic [127:0] m_res = '0;
  logic         m_flag = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Model built from the arithmetic statements in the requirements
  task automatic model(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] op, input logic skip,
                       input logic [3:0] en);
    logic c;
    longint unsigned av, bv, nb;
    c = (op[1] && !skip) ? op[0] : m_flag;
    for (int i = (skip ? 1 : 0); i < 4; i++) begin
      if (en[i]) begin
        av = longint'(a[i*32 +: 32]);
        bv = longint'(b[i*32 +: 32]);
        if (op[0]) begin
          nb = bv + (c ? 0 : 1);
          m_res[i*32 +: 32] = 32'(av - nb);
          c = (av >= nb);
        end else begin
          m_res[i*32 +: 32] = 32'(av + bv + (c ? 1 : 0));
          c = ((av + bv + (c ? 1 : 0)) >> 32) != 0;
        end
      end
    end
    m_flag = c;
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                     input logic [1:0] op, input logic skip, input logic [3:0] en,
                     input bit poke_busy);
    item_t it;
    @(negedge clk);
    it.flag_before = m_flag;
    it.done_cyc = cyc + (skip ? 4 : 5);
    model(a, b, op, skip, en);
    it.res = m_res;
    it.flag = m_flag;
    it.tag = tag;
    sbq.push_back(it);
    a_i = a; b_i = b; op_i = op; skip_first_i = skip; beat_en_i = en;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      a_i = ~a; b_i = 128'h1; op_i = ~op; skip_first_i = ~skip; beat_en_i = ~en;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy_o && sbq.size() > 0)
        check(carry_flag_o == sbq[0].flag_before, "R7 flag held mid-run",
              128'(carry_flag_o), 128'(sbq[0].flag_before));
      if (done_o) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R10 unexpected done", 128'(1), 128'(0));
        end else begin
          item_t it;
          it = sbq.pop_front();
          check(result_o == it.res, {it.tag, " result"}, result_o, it.res);
          check(carry_flag_o == it.flag, {it.tag, " flag R7"},
                128'(carry_flag_o), 128'(it.flag));
          check(cyc == it.done_cyc, {it.tag, " done timing R10"},
                128'(cyc), 128'(it.done_cyc));
        end
      end
      if (done_o && sbq.size() == 0) begin
        @(negedge clk);
        check(!done_o, "R10 done single cycle", 128'(done_o), 128'(0));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 128'(cyc), 128'(0));
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(result_o == '0, "R12 result", result_o, '0);
    check(carry_flag_o == 1'b0, "R12 flag", 128'(carry_flag_o), 128'(0));
    check(done_o == 1'b0 && busy_o == 1'b0, "R12 done/busy",
          128'({done_o, busy_o}), 128'(0));
    rst_n = 1'b1;

    run("R1 R4 fixed add plain", {32'd40, 32'd30, 32'd20, 32'd10},
        {32'd4, 32'd3, 32'd2, 32'd1}, 2'b10, 1'b0, 4'hF, 0);
    run("R3 R4 ripple across lanes", {4{32'hFFFF_FFFF}},
        {96'h0, 32'h1}, 2'b10, 1'b0, 4'hF, 0);
    run("R2 R5 fixed sub equal", {32'h5, 32'h7, 32'h9, 32'hB},
        {32'h5, 32'h7, 32'h9, 32'hB}, 2'b11, 1'b0, 4'hF, 0);
    run("R2 R3 R5 fixed sub borrow", {32'h10, 32'h0, 32'h0, 32'h0},
        {32'h1, 32'h0, 32'h0, 32'h1}, 2'b11, 1'b0, 4'hF, 0);
    run("R6 flag add with set flag", {32'h1, 32'h2, 32'hFFFF_FFFF, 32'h8000_0000},
        {32'h1, 32'h2, 32'h0, 32'h8000_0000}, 2'b00, 1'b0, 4'hF, 0);
    run("R6 flag sub", {32'h3, 32'h3, 32'h3, 32'h3},
        {32'h1, 32'h2, 32'h3, 32'h4}, 2'b01, 1'b0, 4'hF, 0);
    run("R1 carry out to flag", {32'hFFFF_FFFF, 96'h0},
        {32'h1, 96'h0}, 2'b10, 1'b0, 4'hF, 0);
    run("R8 skip with fixed add", {32'hA, 32'hB, 32'hFFFF_FFFF, 32'hDEAD},
        {32'h1, 32'h1, 32'h0, 32'hBEEF}, 2'b10, 1'b1, 4'hF, 0);
    run("R8 skip with fixed sub", {32'h9, 32'h9, 32'h9, 32'h1234},
        {32'h1, 32'h1, 32'h9, 32'h1}, 2'b11, 1'b1, 4'hF, 0);
    run("R9 masked beats", {32'h11, 32'h22, 32'hFFFF_FFFF, 32'h44},
        {32'h1, 32'h1, 32'h1, 32'h1}, 2'b10, 1'b0, 4'b1010, 0);
    run("R9 all beats off", {4{32'h7}}, {4{32'h7}}, 2'b11, 1'b0, 4'h0, 0);
    run("R11 start while busy", {32'h100, 32'h200, 32'h300, 32'h400},
        {32'h1, 32'h2, 32'h3, 32'h4}, 2'b00, 1'b0, 4'hF, 1);
    run("R3 R6 flag sub chain", {4{32'h0}}, {4{32'h0}}, 2'b01, 1'b0, 4'hF, 0);

    check(sbq.size() == 0, "R10 all items retired", 128'(sbq.size()), 128'(0));
    report();
  end
endmodule